// File: doc/BRIEF.md
# Set-associative cache tag controller

This block keeps the tag, recency and dirty state of a set-associative cache and takes in one memory reference per clock. Each reference has a two-bit kind (data read, data write, instruction fetch) and an address. The block splits the address into offset, set index and tag. It reports hit or miss and reorders the set's recency list. On a miss it picks a victim and installs the new tag. It also keeps running totals of references and hits, so that the hit rate of a reference stream can be measured. No data array is held, and no write-back is performed. When a dirty line is replaced, the block raises a flag and shows the old tag.

Two replacement options can be changed on every reference. With `lru_insert` high, a line that has just been filled is placed at the least-recently-used end of its set rather than the most-recently-used end. A line that is filled and never read again is then the first one displaced on the next miss. With `sticky_en` high, a dirty line carries a small protection counter. Victim selection passes over a protected line and wears its counter down each time it does so. Dirty lines therefore stay resident a little longer before they are thrown out.

Top module: `cache_tag_ctrl`

## Requirements
- R1: Geometry comes from CACHE_BYTES, WAYS and LINE_BYTES. The set index is taken from the address bits just above the line offset, and the tag from the bits above the index. With the defaults (1024 bytes, 4 ways, 16-byte lines), the index is addr[7:4] and the tag is addr[31:8]. The offset bits addr[3:0] have no effect on the lookup.
- R2: The kind codes are 0 for a data read, 1 for a data write and 2 for an instruction fetch. Codes 0, 2 and 3 all behave as reads. The result of a reference (resp_valid high, resp_hit) is registered at the same clock edge that samples `ref_valid`. resp_valid is low after a cycle with no reference.
- R3: Reset leaves every line invalid. It also sets every set's recency order to way 0 most recent through way WAYS-1 least recent. With `lru_insert`=0, a miss replaces the line chosen as victim and places the new line at the most-recent position.
- R4: With `lru_insert`=1, the newly filled line takes the least-recent position of its set, so the next miss to that set replaces it again.
- R5: A hit in either mode moves the line to the most-recent position. The lines that were more recent than it each move down by one place.
- R6: A write hit or a write miss fill marks the line dirty and loads its protection counter with STICKY_MAX (default 2). A read fill leaves the line clean with a zero counter. A read hit changes neither the dirty bit nor the counter.
- R7: With `sticky_en`=1, victim selection walks from the least-recent line towards the most-recent one. It skips every valid dirty line whose counter is nonzero and decrements that counter. The first line that is not skipped becomes the victim.
- R8: If `sticky_en`=1 and every line of the set is valid, dirty and protected, the least-recent line is evicted and no counter changes.
- R9: With `sticky_en`=0, the victim is always the least-recent line, whatever its dirty bit and counter hold.
- R10: For one cycle, together with the miss response, `evict_dirty` is high exactly when the replaced line was valid and dirty. In that cycle `evict_tag` holds the replaced line's tag. `evict_dirty` is low on hits and on idle cycles.
- R11: `ref_count` counts accepted references and `hit_count` counts hits. Reset clears both counters, and cycles without a reference leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | A reference is presented this cycle |
| ref_type | input | 2 | Reference kind: 0 read, 1 write, 2 fetch |
| ref_addr | input | ADDR_W (32) | Reference address |
| lru_insert | input | 1 | 1: fills go to the least-recent position; 0: to the most-recent position |
| sticky_en | input | 1 | Enables protection of dirty lines by their counters |
| resp_valid | output | 1 | A lookup result is presented |
| resp_hit | output | 1 | The reference hit |
| evict_dirty | output | 1 | A dirty line was replaced by this miss |
| evict_tag | output | TAG_W (24) | Tag of the replaced line |
| ref_count | output | CNT_W (32) | References seen since reset |
| hit_count | output | CNT_W (32) | Hits seen since reset |

## Verification
Every result of a reference is registered at the rising edge that samples that reference: the hit flag, the dirty-eviction flag and tag, and both counters. All of them are therefore due one clock after the reference is presented. The bench drives a new reference on each falling edge and samples the outputs shortly after the following rising edge, before the next reference is applied. This tests back-to-back references to the same set, where each lookup must see the state that the previous reference left behind. Idle and reset cycles are checked in the cycle after they are applied, to show that responses drop and the counters stay unchanged or return to zero.

// File: rtl/cache_tag_pkg.sv
`timescale 1ns/1ps
package cache_tag_pkg;
  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_SPARE = 2'd3
  } ref_kind_e;
endpackage

// File: rtl/cache_recency_shift.sv
`timescale 1ns/1ps
// Moves one way to the front (MRU) or the back (LRU) of a recency list.
module cache_recency_shift #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAY_W-1:0] ord_in  [WAYS],
  input  logic [WAY_W-1:0] way,
  input  logic             to_back,
  output logic [WAY_W-1:0] ord_out [WAYS]
);
  int pos;

  always_comb begin
    pos = 0;
    for (int i = 0; i < WAYS; i++)
      if (ord_in[i] == way) pos = i;
    for (int i = 0; i < WAYS; i++) ord_out[i] = ord_in[i];
    if (!to_back) begin
      ord_out[0] = way;
      for (int i = 1; i < WAYS; i++)
        ord_out[i] = (i <= pos) ? ord_in[i-1] : ord_in[i];
    end else begin
      ord_out[WAYS-1] = way;
      for (int i = 0; i < WAYS-1; i++)
        ord_out[i] = (i >= pos) ? ord_in[i+1] : ord_in[i];
    end
  end
endmodule

// File: rtl/cache_victim_sel.sv
`timescale 1ns/1ps
// Walks the recency list from LRU upward, passing over protected dirty lines.
module cache_victim_sel #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2,
  parameter int STK_W = 2
) (
  input  logic [WAY_W-1:0] ord    [WAYS],
  input  logic [WAYS-1:0]  valid,
  input  logic [WAYS-1:0]  dirty,
  input  logic [STK_W-1:0] stk    [WAYS],
  input  logic             protect_en,
  output logic [WAY_W-1:0] victim,
  output logic [WAYS-1:0]  skipped
);
  logic             found;
  logic [WAY_W-1:0] w;
  logic [WAYS-1:0]  mask;

  always_comb begin
    found  = 1'b0;
    victim = ord[WAYS-1];
    mask   = '0;
    w      = '0;
    for (int p = WAYS-1; p >= 0; p--) begin
      w = ord[p];
      if (!found) begin
        if (protect_en && valid[w] && dirty[w] && (stk[w] != '0)) begin
          mask[w] = 1'b1;
        end else begin
          found  = 1'b1;
          victim = w;
        end
      end
    end
    if (!found) mask = '0;
    skipped = mask;
  end
endmodule

// File: rtl/cache_tag_ctrl.sv
`timescale 1ns/1ps
module cache_tag_ctrl #(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 1024,
  parameter int WAYS        = 4,
  parameter int LINE_BYTES  = 16,
  parameter int STICKY_MAX  = 2,
  parameter int CNT_W       = 32,
  localparam int SETS  = CACHE_BYTES / (WAYS * LINE_BYTES),
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_valid,
  input  logic [1:0]        ref_type,
  input  logic [ADDR_W-1:0] ref_addr,
  input  logic              lru_insert,
  input  logic              sticky_en,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              evict_dirty,
  output logic [TAG_W-1:0]  evict_tag,
  output logic [CNT_W-1:0]  ref_count,
  output logic [CNT_W-1:0]  hit_count
);
  import cache_tag_pkg::*;

  localparam int WAY_W = $clog2(WAYS);
  localparam int STK_W = $clog2(STICKY_MAX + 1);

  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [STK_W-1:0] stk_q   [SETS][WAYS];
  logic [WAY_W-1:0] ord_q   [SETS][WAYS];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             is_wr;
  logic [WAYS-1:0]  hit_vec;
  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] vic_way;
  logic [WAYS-1:0]  skip_mask;
  logic [WAY_W-1:0] touch_way;
  logic [WAY_W-1:0] cur_ord [WAYS];
  logic [STK_W-1:0] cur_stk [WAYS];
  logic [WAY_W-1:0] new_ord [WAYS];
  logic             unused_offset;

  assign idx           = ref_addr[OFF_W +: IDX_W];
  assign tag           = ref_addr[OFF_W+IDX_W +: TAG_W];
  assign is_wr         = (ref_kind_e'(ref_type) == KIND_WRITE);
  assign unused_offset = ^ref_addr[OFF_W-1:0];

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = valid_q[idx][w] && (tag_q[idx][w] == tag);
      cur_ord[w] = ord_q[idx][w];
      cur_stk[w] = stk_q[idx][w];
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end
  assign hit       = |hit_vec;
  assign touch_way = hit ? hit_way : vic_way;

  cache_victim_sel #(.WAYS(WAYS), .WAY_W(WAY_W), .STK_W(STK_W)) u_victim (
    .ord        (cur_ord),
    .valid      (valid_q[idx]),
    .dirty      (dirty_q[idx]),
    .stk        (cur_stk),
    .protect_en (sticky_en),
    .victim     (vic_way),
    .skipped    (skip_mask)
  );

  cache_recency_shift #(.WAYS(WAYS), .WAY_W(WAY_W)) u_recency (
    .ord_in  (cur_ord),
    .way     (touch_way),
    .to_back (!hit && lru_insert),
    .ord_out (new_ord)
  );

  // Tag store: no reset, one write port, guarded by valid bits.
  always_ff @(posedge clk) begin
    if (ref_valid && !hit && !rst) tag_q[idx][vic_way] <= tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          stk_q[s][w] <= '0;
          ord_q[s][w] <= WAY_W'(w);
        end
      end
      resp_valid  <= 1'b0;
      resp_hit    <= 1'b0;
      evict_dirty <= 1'b0;
      evict_tag   <= '0;
      ref_count   <= '0;
      hit_count   <= '0;
    end else begin
      resp_valid  <= ref_valid;
      resp_hit    <= ref_valid && hit;
      evict_dirty <= 1'b0;
      if (ref_valid) begin
        ref_count <= ref_count + CNT_W'(1);
        for (int w = 0; w < WAYS; w++) ord_q[idx][w] <= new_ord[w];
        if (hit) begin
          hit_count <= hit_count + CNT_W'(1);
          if (is_wr) begin
            dirty_q[idx][hit_way] <= 1'b1;
            stk_q[idx][hit_way]   <= STK_W'(STICKY_MAX);
          end
        end else begin
          for (int w = 0; w < WAYS; w++)
            if (skip_mask[w]) stk_q[idx][w] <= stk_q[idx][w] - STK_W'(1);
          evict_dirty           <= valid_q[idx][vic_way] && dirty_q[idx][vic_way];
          evict_tag             <= tag_q[idx][vic_way];
          valid_q[idx][vic_way] <= 1'b1;
          dirty_q[idx][vic_way] <= is_wr;
          stk_q[idx][vic_way]   <= is_wr ? STK_W'(STICKY_MAX) : '0;
        end
      end
    end
  end
endmodule

// File: rtl/cache_tag_ctrl_chk.sv
`timescale 1ns/1ps
module cache_tag_ctrl_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             ref_valid,
  input logic             resp_valid,
  input logic             resp_hit,
  input logic             evict_dirty,
  input logic [CNT_W-1:0] ref_count,
  input logic [CNT_W-1:0] hit_count
);
  assert_resp_follows_ref_R2: assert property (@(posedge clk) disable iff (rst)
    ref_valid |=> resp_valid);

  assert_no_resp_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !ref_valid |=> !resp_valid && !resp_hit);

  assert_evict_only_on_miss_R10: assert property (@(posedge clk) disable iff (rst)
    evict_dirty |-> resp_valid && !resp_hit);

  assert_ref_count_step_R11: assert property (@(posedge clk) disable iff (rst)
    ref_valid |=> ref_count == $past(ref_count) + CNT_W'(1));

  assert_idle_counts_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !ref_valid |=> $stable(ref_count) && $stable(hit_count));

  assert_hits_bounded_R11: assert property (@(posedge clk) disable iff (rst)
    hit_count <= ref_count);
endmodule

bind cache_tag_ctrl cache_tag_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ref_valid   (ref_valid),
  .resp_valid  (resp_valid),
  .resp_hit    (resp_hit),
  .evict_dirty (evict_dirty),
  .ref_count   (ref_count),
  .hit_count   (hit_count)
);

// File: tb/test_cache_tag_ctrl.sv
`timescale 1ns/1ps
module test_cache_tag_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_valid = 1'b0;
  logic [1:0]  ref_type = 2'd0;
  logic [31:0] ref_addr = '0;
  logic        lru_insert = 1'b0;
  logic        sticky_en = 1'b0;
  logic        resp_valid, resp_hit, evict_dirty;
  logic [23:0] evict_tag;
  logic [31:0] ref_count, hit_count;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cache_tag_ctrl i_cache_tag_ctrl (
    .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_type(ref_type),
    .ref_addr(ref_addr), .lru_insert(lru_insert), .sticky_en(sticky_en),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .evict_dirty(evict_dirty),
    .evict_tag(evict_tag), .ref_count(ref_count), .hit_count(hit_count)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Address: tag in addr[31:8], set in addr[7:4], offset in addr[3:0] (R1)
  task automatic drive(input logic [1:0] kind, input logic [7:0] t,
                       input logic [3:0] s, input logic [3:0] off,
                       input logic mode, input logic sen);
    ref_valid  = 1'b1;
    ref_type   = kind;
    ref_addr   = {16'h0, t, s, off};
    lru_insert = mode;
    sticky_en  = sen;
  endtask

  // Fields: [29:26] req, [25:24] kind, [23] lru_insert, [22] sticky_en,
  // [21:14] tag, [13:10] set, [9] hit, [8] evict_dirty, [7:0] evict_tag
  localparam int NV = 29;
  localparam logic [29:0] VEC [NV] = '{
    {4'd3,  2'd0,1'b0,1'b0,8'd1,4'd0,1'b0,1'b0,8'd0},  // R3 fill way3
    {4'd5,  2'd0,1'b0,1'b0,8'd1,4'd0,1'b1,1'b0,8'd0},  // R5 hit
    {4'd6,  2'd1,1'b0,1'b0,8'd2,4'd0,1'b0,1'b0,8'd0},  // R6 write fill
    {4'd2,  2'd2,1'b0,1'b0,8'd3,4'd0,1'b0,1'b0,8'd0},  // R2 fetch fill
    {4'd3,  2'd0,1'b0,1'b0,8'd4,4'd0,1'b0,1'b0,8'd0},  // R3 set full
    {4'd3,  2'd0,1'b0,1'b0,8'd5,4'd0,1'b0,1'b0,8'd0},  // R3 clean victim
    {4'd10, 2'd0,1'b0,1'b0,8'd6,4'd0,1'b0,1'b1,8'd2},  // R10 dirty victim
    {4'd5,  2'd0,1'b0,1'b0,8'd3,4'd0,1'b1,1'b0,8'd0},  // R5
    {4'd6,  2'd1,1'b0,1'b0,8'd4,4'd0,1'b1,1'b0,8'd0},  // R6 write hit
    {4'd5,  2'd0,1'b0,1'b0,8'd3,4'd0,1'b1,1'b0,8'd0},  // R5
    {4'd5,  2'd0,1'b0,1'b0,8'd6,4'd0,1'b1,1'b0,8'd0},  // R5
    {4'd5,  2'd0,1'b0,1'b0,8'd5,4'd0,1'b1,1'b0,8'd0},  // R5 dirty tag4 now LRU
    {4'd7,  2'd0,1'b0,1'b1,8'd7,4'd0,1'b0,1'b0,8'd0},  // R7 skip tag4
    {4'd7,  2'd0,1'b0,1'b1,8'd8,4'd0,1'b0,1'b0,8'd0},  // R7 skip again
    {4'd7,  2'd0,1'b0,1'b1,8'd9,4'd0,1'b0,1'b1,8'd4},  // R7 counter worn out
    {4'd7,  2'd0,1'b0,1'b0,8'd4,4'd0,1'b0,1'b0,8'd0},  // R7 tag4 gone
    {4'd4,  2'd2,1'b1,1'b0,8'd1,4'd1,1'b0,1'b0,8'd0},  // R4 fill at LRU
    {4'd4,  2'd0,1'b1,1'b0,8'd2,4'd1,1'b0,1'b0,8'd0},  // R4 replaces it
    {4'd4,  2'd0,1'b1,1'b0,8'd1,4'd1,1'b0,1'b0,8'd0},  // R4 tag1 was lost
    {4'd5,  2'd0,1'b1,1'b0,8'd1,4'd1,1'b1,1'b0,8'd0},  // R5 hit in LRU mode
    {4'd4,  2'd0,1'b1,1'b0,8'd3,4'd1,1'b0,1'b0,8'd0},  // R4 spares promoted line
    {4'd5,  2'd0,1'b0,1'b0,8'd1,4'd1,1'b1,1'b0,8'd0},  // R5 still present
    {4'd6,  2'd1,1'b0,1'b1,8'd1,4'd2,1'b0,1'b0,8'd0},  // R6
    {4'd6,  2'd1,1'b0,1'b1,8'd2,4'd2,1'b0,1'b0,8'd0},  // R6
    {4'd6,  2'd1,1'b0,1'b1,8'd3,4'd2,1'b0,1'b0,8'd0},  // R6
    {4'd6,  2'd1,1'b0,1'b1,8'd4,4'd2,1'b0,1'b0,8'd0},  // R6 all dirty
    {4'd8,  2'd0,1'b0,1'b1,8'd5,4'd2,1'b0,1'b1,8'd1},  // R8 all protected
    {4'd7,  2'd0,1'b0,1'b1,8'd6,4'd2,1'b0,1'b0,8'd0},  // R7 skip three
    {4'd9,  2'd0,1'b0,1'b0,8'd7,4'd2,1'b0,1'b1,8'd2}   // R9 protection off
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [29:0] v;
    string req;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "reset ref_count", ref_count, 32'd0);
    chk("R11", "reset hit_count", hit_count, 32'd0);
    chk("R2", "reset resp_valid", 32'(resp_valid), 32'd0);
    chk("R10", "reset evict_dirty", 32'(evict_dirty), 32'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      req = $sformatf("R%0d vec%0d", v[29:26], k);
      @(negedge clk);
      drive(v[25:24], v[21:14], v[13:10], 4'h0, v[23], v[22]);
      @(posedge clk);
      #1;
      chk(req, "resp_valid", 32'(resp_valid), 32'd1);
      chk(req, "resp_hit", 32'(resp_hit), 32'(v[9]));
      chk(req, "evict_dirty", 32'(evict_dirty), 32'(v[8]));
      if (v[8]) chk(req, "evict_tag", 32'(evict_tag), 32'(v[7:0]));
    end

    // R11: idle cycle, then the totals of the table (29 refs, 8 hits)
    @(negedge clk);
    ref_valid = 1'b0;
    @(posedge clk);
    #1;
    chk("R2", "idle resp_valid", 32'(resp_valid), 32'd0);
    chk("R10", "idle evict_dirty", 32'(evict_dirty), 32'd0);
    chk("R11", "ref_count", ref_count, 32'd29);
    chk("R11", "hit_count", hit_count, 32'd8);
    @(posedge clk);
    #1;
    chk("R11", "ref_count held", ref_count, 32'd29);
    chk("R11", "hit_count held", hit_count, 32'd8);

    // R1: offset bits do not affect the lookup (tag3 sits in set 2)
    @(negedge clk);
    drive(2'd0, 8'd3, 4'd2, 4'hC, 1'b0, 1'b0);
    @(posedge clk);
    #1;
    chk("R1", "hit with nonzero offset", 32'(resp_hit), 32'd1);
    chk("R11", "hit_count after R1", hit_count, 32'd9);

    // R3: reset invalidates lines and clears counters
    @(negedge clk);
    ref_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R11", "ref_count after reset", ref_count, 32'd0);
    chk("R11", "hit_count after reset", hit_count, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    drive(2'd0, 8'd3, 4'd2, 4'h0, 1'b0, 1'b0);
    @(posedge clk);
    #1;
    chk("R3", "miss after reset", 32'(resp_hit), 32'd0);
    chk("R10", "clean victim after reset", 32'(evict_dirty), 32'd0);
    chk("R11", "ref_count one", ref_count, 32'd1);
    @(negedge clk);
    ref_valid = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule